// File: doc/BRIEF.md
# Measurement Trigger, Gate Window and Stimulus Pulse Generator

This block turns one fast time base into the control timing for a measurement. Two gate windows open when a measurement starts and stay open for a programmed number of time-base cycles. A start comes from one of two places. One is an asynchronous external trigger line, whose active edge can be chosen as rising or falling. The other is a one-cycle software strobe.

Each gate has its own enable bit and its own length. Each gate also has its own bit that says whether the external trigger may open it. A third part generates a periodic single-cycle stimulus pulse. Its period is counted in ticks of a slower enable taken from the time base, and the period has a lower bound.

Configuration arrives through a simple synchronous register write port. A write is visible from the clock edge that samples it.

Top module: `meas_ctrl_timing`

## Requirements
- R1: While reset is asserted, both gate outputs and the fire output are low.
- R2: A software strobe sampled high on clock edge k opens every enabled gate (control bit 1 for gate 0, bit 3 for gate 1) immediately after edge k. The gate stays high for exactly the number of cycles in its length register (address 1 for gate 0, address 2 for gate 1, 24 bits).
- R3: A gate whose length register holds zero produces no pulse at all when started.
- R4: The external trigger passes two synchronizing flops and then an edge detector, so a gate opens right after the third clock edge that follows the input transition. Control bit 0 selects the active edge (0 rising, 1 falling). The other edge opens nothing.
- R5: The external trigger opens a gate only if that gate's trigger-select bit is set (control bit 2 for gate 0, bit 4 for gate 1). The software strobe opens an enabled gate whatever that bit holds.
- R6: A gate whose enable bit is clear stays low regardless of strobes or triggers.
- R7: A start that arrives while a gate is open is ignored for that gate, and the gate closes at its original time.
- R8: With the fire enable (control bit 5) set and a period register (address 3) value P of at least 10, the first fire pulse comes 4 cycles after the enabling write edge. Later pulses follow every 4*P cycles, and each pulse is one cycle wide.
- R9: A period register value below 10 acts as 10, giving a spacing of 40 cycles.
- R10: A new period written while the fire generator runs takes effect only after the pulse that ends the current period.
- R11: The two gates time independently, so different lengths started together give different pulse widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 gate 0 length, 2 gate 1 length, 3 fire period |
| cfg_wdata | input | 24 | Register write data |
| trig_ext | input | 1 | Asynchronous external trigger line |
| sw_start | input | 1 | One-cycle software start strobe |
| gate_o | output | 2 | Gate windows, bit i for gate i |
| fire_o | output | 1 | Single-cycle stimulus pulse |

## Verification
A gate is due in the first cycle after the edge that samples the strobe. After an external transition, the gate is due after the third edge, because the two synchronizer flops and the gate counter each add one edge. The first fire pulse is due four edges after the enabling write, which is the time the prescaler takes to reach its terminal tick.

The bench drives inputs on falling edges and samples the outputs on falling edges. It records the sample index at which each output first goes high, counts the high samples in a fixed window, and compares these indices and widths with values computed from these latencies.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int NG      = 2;   // gate count
  localparam int LEN_W   = 24;  // gate length and data width
  localparam int PER_W   = 24;  // fire period width
  localparam int ADDR_W  = 2;
  localparam int DIV     = 4;   // time base cycles per fire tick
  localparam int MIN_PER = 10;  // smallest fire period in ticks
  localparam int CTRL_W  = 2 * NG + 2;
  localparam int FIRE_BIT = 2 * NG + 1;

  function automatic int gate_en_bit(input int i);
    return 1 + 2 * i;
  endfunction

  function automatic int gate_ext_bit(input int i);
    return 2 + 2 * i;
  endfunction

  function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
    return (p < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : p;
  endfunction
endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              synced;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign synced = sh_q[STAGES-1];
  assign edge_o = fall_sel ? (prev_q & ~synced) : (synced & ~prev_q);

  // R4
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o && $stable(fall_sel) |=> !edge_o || (fall_sel != $past(fall_sel)));
endmodule

// File: rtl/mct_gate.sv
module mct_gate #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             open_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) cnt_q <= '0;
    else if (cnt_q != '0)  cnt_q <= cnt_q - LEN_W'(1);
    else if (start)        cnt_q <= len;
  end

  assign open_o = (cnt_q != '0);

  // R2
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && start && !open_o && (len != '0) |=> open_o);
  // R3
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_o && (len == '0) |=> !open_o);
  // R6
  disabled_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !open_o);
  // R7
  retrig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && open_o && start |=> cnt_q == $past(cnt_q) - LEN_W'(1));
endmodule

// File: rtl/mct_fire.sv
module mct_fire
  import mct_pkg::*;
#(
  parameter int P_W = PER_W,
  parameter int D   = DIV
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [P_W-1:0] period,
  output logic           fire_o
);
  localparam int PS_W = (D > 1) ? $clog2(D) : 1;

  logic [PS_W-1:0] presc_q;
  logic [P_W-1:0]  pcnt_q;
  logic            tick;

  assign tick = (presc_q == PS_W'(D - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      presc_q <= '0;
      pcnt_q  <= '0;
      fire_o  <= 1'b0;
    end else begin
      presc_q <= tick ? '0 : presc_q + PS_W'(1);
      fire_o  <= tick && (pcnt_q == '0);
      if (tick) pcnt_q <= (pcnt_q == '0) ? eff_period(period) - P_W'(1)
                                         : pcnt_q - P_W'(1);
    end
  end

  // R8
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  // R8
  fire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(tick));
  // R9
  fire_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> pcnt_q >= P_W'(MIN_PER - 1));
endmodule

// File: rtl/meas_ctrl_timing.sv
module meas_ctrl_timing
  import mct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_wdata,
  input  logic              trig_ext,
  input  logic              sw_start,
  output logic [NG-1:0]     gate_o,
  output logic              fire_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [LEN_W-1:0]  len_q [NG];
  logic [PER_W-1:0]  per_q;
  logic              trig_edge;
  logic [NG-1:0]     gate_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= PER_W'(MIN_PER);
    end else if (cfg_we) begin
      if (cfg_addr == '0)               ctrl_q <= cfg_wdata[CTRL_W-1:0];
      if (cfg_addr == ADDR_W'(NG + 1))  per_q  <= PER_W'(cfg_wdata);
    end
  end

  mct_edge_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_ext),
    .fall_sel(ctrl_q[0]),
    .edge_o  (trig_edge)
  );

  for (genvar i = 0; i < NG; i++) begin : g_gate
    always_ff @(posedge clk) begin
      if (!rst_n) len_q[i] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(i + 1)) len_q[i] <= cfg_wdata;
    end

    assign gate_start[i] = sw_start | (ctrl_q[gate_ext_bit(i)] & trig_edge);

    mct_gate #(.LEN_W(LEN_W)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(ctrl_q[gate_en_bit(i)]),
      .start (gate_start[i]),
      .len   (len_q[i]),
      .open_o(gate_o[i])
    );

    // R5
    gate_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o[i]) |-> $past(sw_start) || $past(trig_edge && ctrl_q[gate_ext_bit(i)]));
  end

  mct_fire #(.P_W(PER_W), .D(DIV)) u_fire (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(ctrl_q[FIRE_BIT]),
    .period(per_q),
    .fire_o(fire_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (gate_o == '0) && !fire_o);
endmodule

// File: tb/test_meas_ctrl_timing.sv
module test_meas_ctrl_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        trig_ext = 1'b0;
  logic        sw_start = 1'b0;
  logic [1:0]  gate_o;
  logic        fire_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  int cnt0, cnt1, first0, first1, nfire;
  int ft [8];

  // {gate 0 length, gate 1 length}
  localparam int VEC [5][2] = '{'{5, 9}, '{1, 1}, '{0, 3}, '{16, 0}, '{2, 7}};

  always #10 clk = ~clk;

  meas_ctrl_timing i_meas_ctrl_timing (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_ext(trig_ext), .sw_start(sw_start),
    .gate_o(gate_o), .fire_o(fire_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 24'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  // sample n falling edges starting now; optional strobe / write at given index
  task automatic measure(input int n, input int sw_at, input int wr_at, input int wr_d);
    cnt0 = 0; cnt1 = 0; first0 = -1; first1 = -1; nfire = 0;
    for (int k = 0; k < n; k++) begin
      sw_start = (k == sw_at);
      if (k == wr_at) begin cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 24'(wr_d); end
      else cfg_we = 1'b0;
      if (gate_o[0]) begin cnt0++; if (first0 < 0) first0 = k; end
      if (gate_o[1]) begin cnt1++; if (first1 < 0) first1 = k; end
      if (fire_o) begin if (nfire < 8) ft[nfire] = k; nfire++; end
      @(negedge clk);
    end
    sw_start = 1'b0;
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(int'(gate_o), 0, "R1 gates in reset");
    check(int'(fire_o), 0, "R1 fire in reset");
    rst_n = 1'b1;

    // both gates enabled, software start only
    wr(0, 'b001010);
    foreach (VEC[v]) begin
      wr(1, VEC[v][0]);
      wr(2, VEC[v][1]);
      strobe();
      measure(40, -1, -1, 0);
      check(cnt0, VEC[v][0], "R2 R3 R11 gate0 width");
      check(cnt1, VEC[v][1], "R2 R3 R11 gate1 width");
      if (VEC[v][0] != 0) check(first0, 0, "R2 gate0 opens after strobe edge");
    end

    // R7 restart while open
    wr(1, 10);
    strobe();
    measure(30, 4, -1, 0);
    check(cnt0, 10, "R7 restart ignored");

    // R6 gate1 disabled
    wr(0, 'b000010);
    wr(2, 5);
    strobe();
    measure(20, -1, -1, 0);
    check(cnt1, 0, "R6 disabled gate");
    check(cnt0, 10, "R6 enabled gate unaffected");

    // R4 / R5 external trigger, gate0 trigger-selected, gate1 not
    wr(0, 'b001110);
    wr(1, 6);
    wr(2, 6);
    @(negedge clk);
    trig_ext = 1'b1;
    measure(20, -1, -1, 0);
    check(first0, 3, "R4 rising edge latency");
    check(cnt0, 6, "R4 triggered width");
    check(cnt1, 0, "R5 unselected gate ignores trigger");
    trig_ext = 1'b0;
    measure(20, -1, -1, 0);
    check(cnt0, 0, "R4 falling edge ignored in rising mode");
    wr(0, 'b001111);
    @(negedge clk);
    trig_ext = 1'b1;
    measure(20, -1, -1, 0);
    check(cnt0, 0, "R4 rising edge ignored in falling mode");
    trig_ext = 1'b0;
    measure(20, -1, -1, 0);
    check(first0, 3, "R4 falling edge latency");
    check(cnt0, 6, "R4 falling triggered width");
    strobe();
    measure(20, -1, -1, 0);
    check(cnt1, 6, "R5 strobe opens unselected gate");

    // R8 fire period 12
    wr(0, 0);
    wr(3, 12);
    wr(0, 'b100000);
    measure(120, -1, -1, 0);
    check(nfire, 3, "R8 pulse count");
    check(ft[0], 4, "R8 first pulse");
    check(ft[1], 52, "R8 second pulse");
    check(ft[2], 100, "R8 third pulse");

    // R9 clamp
    wr(0, 0);
    wr(3, 3);
    wr(0, 'b100000);
    measure(100, -1, -1, 0);
    check(nfire, 3, "R9 pulse count");
    check(ft[1], 44, "R9 clamped spacing");
    check(ft[2], 84, "R9 clamped spacing");

    // R10 new period at boundary
    wr(0, 0);
    wr(3, 10);
    wr(0, 'b100000);
    measure(130, -1, 20, 20);
    check(nfire, 3, "R10 pulse count");
    check(ft[1], 44, "R10 old period completes");
    check(ft[2], 124, "R10 new period applied");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule